// File: doc/BRIEF.md
# Bus Start-Condition Watchdog Timer

This block supervises a host processor by watching a two-wire serial bus. The only thing that restarts the timer is a start condition on the bus, meaning SDA falls while SCL is high. If the host lets the selected period run out without producing one, the block raises a reset request. The request is held for a fixed number of cycles. After that the timer starts again from zero.

A two-bit selector picks one of three timeout periods or turns the watchdog off. The host writes the selector through a plain strobe-and-data write port. A write-protect pin freezes the selector against change. A power-good flag from an external comparator holds the timer at rest while the supply is low. The periods are scaled down so that they are short in clock cycles.

Top module: `bus_kick_watchdog`

## Requirements
- R1: A kick is a high-to-low change of SDA while SCL is high, with both lines taken through a two-stage synchronizer. SDA changes while SCL is low do not restart the timer.
- R2: The selector encodes the period: 2'b00 gives 2^10 cycles, 2'b01 gives 2^12 cycles and 2'b10 gives 2^14 cycles. The reset request rises exactly one period of clock edges after the edge that last cleared the counter.
- R3: A kick clears the counter on the third rising clock edge after SDA falls at the pin.
- R4: A write with write-protect low loads `sel_wr_data` on the next edge, shows it on `period_sel`, and clears the counter on that same edge.
- R5: While `wp_in` is high, a write changes neither `period_sel` nor the timeout timing.
- R6: Selector 2'b11 disables the watchdog, and no reset request is raised.
- R7: The reset request stays high for exactly 16 cycles. Kicks and writes made during that time do not shorten it. After release, the next timeout comes one full period later.
- R8: While `pwr_good` is low, the counter stays at zero and the request stays low. Counting restarts from zero when `pwr_good` returns high.
- R9: After reset, `wdt_rst_req` is 0 and `period_sel` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sda_in | input | 1 | Serial data line, asynchronous |
| scl_in | input | 1 | Serial clock line, asynchronous |
| wp_in | input | 1 | Write protect; high locks the selector |
| sel_wr_en | input | 1 | One-cycle write strobe for the selector |
| sel_wr_data | input | 2 | New selector value |
| pwr_good | input | 1 | Supply-good flag; low holds the timer |
| wdt_rst_req | output | 1 | Timeout reset request |
| period_sel | output | 2 | Current selector value |

## Verification
The hardest case to reach from the ports is a start condition that lands inside the reset-request hold window. It has to be timed against a timeout that is itself thousands of cycles away. The bench counts every clock edge. It computes each expected rise and fall edge from the last clearing event plus the period and hold length. It places kicks and writes inside the predicted window and then checks that the release edge does not move. Each of the three periods is swept twice, once restarted by a write and once by a kick, so that the two clearing latencies are each measured.

// File: rtl/bkw_pkg.sv
package bkw_pkg;
  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/bkw_sync.sv
module bkw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // idle bus level is high, so reset the chain high
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[i] <= '1;
        else if (i == 0) stage_q[i] <= d_async;
        else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/bkw_start_det.sv
module bkw_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic kick
);
  logic sda_q, scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_s;
      scl_q <= scl_s;
    end
  end

  // SDA falls between samples while SCL stays high in both
  assign kick = sda_q & ~sda_s & scl_q & scl_s;
endmodule

// File: rtl/bkw_sel_reg.sv
module bkw_sel_reg
  import bkw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_in,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output wd_sel_e    sel,
  output logic       wr_taken
);
  wd_sel_e sel_q;

  assign wr_taken = wr_en & ~wp_in;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= WD_SHORT;
    else if (wr_taken) sel_q <= wd_sel_e'(wr_data);
  end

  assign sel = sel_q;

  assert_wp_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wp_in) |=> $stable(sel_q));
  assert_write_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wp_in) |=> (sel_q == wd_sel_e'($past(wr_data))));
endmodule

// File: rtl/bkw_timer.sv
module bkw_timer
  import bkw_pkg::*;
#(
  parameter int P0_LOG      = 10,
  parameter int P1_LOG      = 12,
  parameter int P2_LOG      = 14,
  parameter int HOLD_CYCLES = 16,
  localparam int CNT_W      = P2_LOG,
  localparam int HOLD_W     = $clog2(HOLD_CYCLES)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwr_good,
  input  logic    kick,
  input  logic    wr_taken,
  input  wd_sel_e sel,
  output logic    req
);
  logic [CNT_W-1:0]  cnt_q, lim;
  logic [HOLD_W-1:0] hold_q;
  logic              req_q;

  always_comb begin
    unique case (sel)
      WD_SHORT: lim = CNT_W'((64'd1 << P0_LOG) - 64'd1);
      WD_MID:   lim = CNT_W'((64'd1 << P1_LOG) - 64'd1);
      default:  lim = CNT_W'((64'd1 << P2_LOG) - 64'd1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_good) begin
      cnt_q  <= '0;
      hold_q <= '0;
      req_q  <= 1'b0;
    end else if (req_q) begin
      cnt_q <= '0;
      if (hold_q == HOLD_W'(HOLD_CYCLES - 1)) begin
        req_q  <= 1'b0;
        hold_q <= '0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end else if (kick || wr_taken || sel == WD_OFF) begin
      cnt_q <= '0;
    end else if (cnt_q == lim) begin
      cnt_q <= '0;
      req_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req = req_q;

  assert_kick_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && pwr_good) |=> (cnt_q == '0));
  assert_off_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == WD_OFF && !req_q) |=> !req_q);
  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (cnt_q == '0));
  assert_hold_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_q) && $past(pwr_good)) |-> ($past(hold_q) == HOLD_W'(HOLD_CYCLES - 1)));
  assert_pg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!req_q && cnt_q == '0));
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim || $past(wr_taken));
endmodule

// File: rtl/bus_kick_watchdog.sv
module bus_kick_watchdog
  import bkw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PER0_LOG    = 10,
  parameter int PER1_LOG    = 12,
  parameter int PER2_LOG    = 14,
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       wp_in,
  input  logic       sel_wr_en,
  input  logic [1:0] sel_wr_data,
  input  logic       pwr_good,
  output logic       wdt_rst_req,
  output logic [1:0] period_sel
);
  logic [1:0] bus_s;
  logic       kick, wr_taken;
  wd_sel_e    sel;

  bkw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async({sda_in, scl_in}), .d_sync(bus_s));

  bkw_start_det u_det (
    .clk(clk), .rst_n(rst_n), .sda_s(bus_s[1]), .scl_s(bus_s[0]), .kick(kick));

  bkw_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n), .wp_in(wp_in), .wr_en(sel_wr_en),
    .wr_data(sel_wr_data), .sel(sel), .wr_taken(wr_taken));

  bkw_timer #(
    .P0_LOG(PER0_LOG), .P1_LOG(PER1_LOG), .P2_LOG(PER2_LOG),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .kick(kick),
    .wr_taken(wr_taken), .sel(sel), .req(wdt_rst_req));

  assign period_sel = sel;
endmodule

// File: tb/bus_kick_watchdog_tb.sv
module bus_kick_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sda = 1'b1, scl = 1'b1, wp = 1'b0, wr_en = 1'b0, pg = 1'b1;
  logic [1:0] wr_data = 2'b00;
  logic req;
  logic [1:0] psel;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  bus_kick_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .sda_in(sda), .scl_in(scl), .wp_in(wp),
    .sel_wr_en(wr_en), .sel_wr_data(wr_data), .pwr_good(pg),
    .wdt_rst_req(req), .period_sel(psel));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int per(int s);
    return 1 << (10 + 2*s);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input int s, output int c);
    @(negedge clk); wr_en = 1'b1; wr_data = 2'(s); c = cyc + 1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_kick(output int c);
    @(negedge clk); sda = 1'b0; c = cyc + 3;
    repeat (4) @(negedge clk);
    sda = 1'b1;
  endtask

  task automatic wait_level(input logic lvl, output int t);
    for (int n = 0; req !== lvl && n < 40000; n++) @(negedge clk);
    t = cyc;
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req) seen = 1;
    end
  endtask

  always @(posedge clk) if (cyc > 190000 && !done) begin
    done = 1; fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int c, t, t2, seen;
    repeat (4) @(negedge clk);
    check("R9 req after reset", req, 0);
    check("R9 period_sel after reset", psel, 0);
    rst_n = 1'b1;

    // R2 R4 R7: write-restarted sweep with hold and re-timeout
    for (int s = 0; s < 3; s++) begin
      do_write(s, c);
      check("R4 period_sel loaded", psel, s);
      wait_level(1'b1, t);  check("R2 timeout edge after write", t, c + per(s));
      wait_level(1'b0, t2); check("R7 hold length", t2, t + HOLD);
      wait_level(1'b1, t);  check("R7 restart after hold", t, t2 + per(s));
      wait_level(1'b0, t2);
    end

    // R3: kick-restarted sweep
    for (int s = 0; s < 3; s++) begin
      do_write(s, c);
      repeat (5) @(negedge clk);
      do_kick(c);
      wait_level(1'b1, t); check("R3 timeout edge after kick", t, c + per(s));
      wait_level(1'b0, t2);
    end

    // R1: SDA toggling while SCL low is not a kick
    do_write(0, c);
    @(negedge clk); scl = 1'b0;
    repeat (3) @(negedge clk); sda = 1'b0;
    repeat (3) @(negedge clk); sda = 1'b1;
    repeat (3) @(negedge clk); sda = 1'b0;
    repeat (3) @(negedge clk); scl = 1'b1;
    repeat (3) @(negedge clk); sda = 1'b1;
    wait_level(1'b1, t); check("R1 no kick with SCL low", t, c + per(0));

    // R7: kick and write during hold do not shorten it
    repeat (2) @(negedge clk);
    do_kick(c);
    do_write(0, c);
    wait_level(1'b0, t2); check("R7 hold unaffected by bus/write", t2, t + HOLD);

    // R5: write-protect locks selector and does not clear counter
    do_write(0, c);
    repeat (100) @(negedge clk);
    wp = 1'b1;
    do_write(2, t2);
    check("R5 period_sel locked", psel, 0);
    wait_level(1'b1, t); check("R5 timing unchanged", t, c + per(0));
    wait_level(1'b0, t2);
    wp = 1'b0;

    // R8: power-good low holds the timer
    do_write(0, c);
    repeat (500) @(negedge clk);
    pg = 1'b0;
    quiet(3000, seen); check("R8 no request while power low", seen, 0);
    pg = 1'b1; c = cyc;
    wait_level(1'b1, t); check("R8 count restarts from zero", t, c + per(0));
    wait_level(1'b0, t2);

    // R6: disabled encoding
    do_write(3, c);
    check("R6 period_sel off", psel, 3);
    quiet(17000, seen); check("R6 no request when disabled", seen, 0);
    do_kick(c);
    quiet(200, seen); check("R6 kick while disabled", seen, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule